// File: doc/BRIEF.md
# Edge-Sensed Interrupt Request Controller

This block gathers interrupt requests for a small microcontroller core and turns them into one request line and a vector number. There are ten sources. Two main external pins each detect either a rising or a falling edge, chosen by one configuration bit per pin, and a per-pin function select must mark the pin as an interrupt input before its edges count. An auxiliary external pin detects a falling edge, a rising edge or both edges. Seven internal strobes come from synchronous peripherals. The external pins pass through a two-flop synchronizer, and an edge is found by comparing the synchronized level with its value one cycle earlier.

Each source latches a flag. A flag takes part in arbitration only while its own enable bit is 1 and the global mask is 0. Among the flags that take part, the source with the lowest fixed vector number wins. That number is placed on a registered 5-bit output with a valid line. When the CPU acknowledges, the global mask is set, so no further request is presented until software clears it. Software reads and writes the edge configuration, enables, flags and mask through a small register port.

Top module: `irq_edge_ctrl`

## Requirements
- R1: Register 0 bit 0 (main pin 0) and bit 1 (main pin 1) select the active edge: 1 means rising, 0 means falling. An active edge sets flag bit 0 or bit 1 of register 3.
- R2: Register 0 bits 3:2 select the auxiliary pin edge: 00 is falling, 01 is rising, 10 and 11 are both edges. An active edge sets bit 2 of register 3.
- R3: A main pin whose bit in `pin_sel` is 0 never sets its flag, whatever edges it sees.
- R4: A 1 on `int_req[k]` sets bit k of register 4 on the next clock edge.
- R5: A flag stays set until software writes 0 to it in register 3 (bits 2:0) or register 4 (bits 6:0). Writing 1 to a flag has no effect.
- R6: When a set event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R7: Register 1 bits 2:0 enable main pin 0, main pin 1 and the auxiliary pin. Register 2 bits 6:0 enable internal sources 0 to 6. A disabled source is left out of arbitration, and the other sources are not affected.
- R8: While the mask (register 5 bit 0) is 1, `irq_req` is 0.
- R9: `irq_ack` sets the mask on the next clock edge. It wins over a write to register 5 in the same cycle.
- R10: The source vectors are: main pin 0 = 4, main pin 1 = 5, auxiliary = 6, internal 0..6 = 20, 19, 18, 15, 14, 12, 11. The lowest vector among enabled, unmasked flags appears on `irq_vec` with `irq_req` = 1, one cycle after the flag state. When nothing is pending, `irq_vec` is 0.
- R11: After reset, every register reads 0. `reg_rdata` shows the register selected by `reg_addr` one cycle later. Configuration writes read back exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 2 | Main external request pins (asynchronous) |
| aux_pin | input | 1 | Auxiliary external request pin (asynchronous) |
| pin_sel | input | 2 | Marks each main pin as an interrupt input |
| int_req | input | 7 | Internal peripheral request strobes |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| irq_ack | input | 1 | CPU acknowledge; sets the mask |
| irq_req | output | 1 | Registered interrupt request |
| irq_vec | output | 5 | Registered winning vector number, 0 when idle |

## Verification
A flag that is latched wrongly shows up in the register 3 or register 4 readback two cycles after the strobe, or up to five cycles after a pin edge once the synchronizer is counted. A wrong priority or enable state shows up on `irq_vec` and `irq_req` one cycle after the enables change. The bench covers every one of the 1024 enable patterns with all flags set, so any misordered or missing vector is exposed. A mask that does not set on acknowledge leaves `irq_req` high in the cycle after the acknowledge.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int NUM_PIN  = 2;
  localparam int NUM_EXT  = 3;
  localparam int NUM_INT  = 7;
  localparam int NUM_SRC  = NUM_EXT + NUM_INT;
  localparam int VEC_W    = 5;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 3;

  localparam logic [ADDR_W-1:0] REG_EDGE    = 3'd0;
  localparam logic [ADDR_W-1:0] REG_EN_EXT  = 3'd1;
  localparam logic [ADDR_W-1:0] REG_EN_INT  = 3'd2;
  localparam logic [ADDR_W-1:0] REG_FLG_EXT = 3'd3;
  localparam logic [ADDR_W-1:0] REG_FLG_INT = 3'd4;
  localparam logic [ADDR_W-1:0] REG_MASK    = 3'd5;

  typedef enum logic [1:0] {
    AUX_FALL  = 2'b00,
    AUX_RISE  = 2'b01,
    AUX_BOTH  = 2'b10,
    AUX_BOTH2 = 2'b11
  } aux_edge_e;

  function automatic logic [VEC_W-1:0] src_vector(input int idx);
    case (idx)
      0: return 5'd4;
      1: return 5'd5;
      2: return 5'd6;
      3: return 5'd20;
      4: return 5'd19;
      5: return 5'd18;
      6: return 5'd15;
      7: return 5'd14;
      8: return 5'd12;
      default: return 5'd11;
    endcase
  endfunction
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES:0] shift_q;
    always_ff @(posedge clk) begin
      if (rst) shift_q <= '0;
      else     shift_q <= {shift_q[STAGES-1:0], pin_in[b]};
    end
    assign rise[b] =  shift_q[STAGES-1] & ~shift_q[STAGES];
    assign fall[b] = ~shift_q[STAGES-1] &  shift_q[STAGES];
  end
endmodule

// File: rtl/irq_flag_regs.sv
module irq_flag_regs
  import irq_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_SRC-1:0] set_evt,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              irq_ack,
  output logic [NUM_PIN-1:0] edge_rise,
  output logic [1:0]        aux_sel,
  output logic [NUM_SRC-1:0] flags,
  output logic [NUM_SRC-1:0] enables,
  output logic              mask,
  output logic [DATA_W-1:0] rdata
);
  logic [NUM_SRC-1:0] clr_req;
  logic               unused_wbit;

  assign unused_wbit = reg_wdata[DATA_W-1];

  always_comb begin
    clr_req = '0;
    if (reg_wr && reg_addr == REG_FLG_EXT)
      clr_req[NUM_EXT-1:0] = ~reg_wdata[NUM_EXT-1:0];
    if (reg_wr && reg_addr == REG_FLG_INT)
      clr_req[NUM_SRC-1:NUM_EXT] = ~reg_wdata[NUM_INT-1:0];
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             flags[i] <= 1'b0;
      else if (set_evt[i]) flags[i] <= 1'b1;
      else if (clr_req[i]) flags[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_rise <= '0;
      aux_sel   <= AUX_FALL;
      enables   <= '0;
      mask      <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == REG_EDGE) begin
        edge_rise <= reg_wdata[NUM_PIN-1:0];
        aux_sel   <= reg_wdata[NUM_PIN+1:NUM_PIN];
      end
      if (reg_wr && reg_addr == REG_EN_EXT)
        enables[NUM_EXT-1:0] <= reg_wdata[NUM_EXT-1:0];
      if (reg_wr && reg_addr == REG_EN_INT)
        enables[NUM_SRC-1:NUM_EXT] <= reg_wdata[NUM_INT-1:0];
      if (irq_ack)
        mask <= 1'b1;
      else if (reg_wr && reg_addr == REG_MASK)
        mask <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      case (reg_addr)
        REG_EDGE:    rdata[NUM_PIN+1:0] <= {aux_sel, edge_rise};
        REG_EN_EXT:  rdata[NUM_EXT-1:0] <= enables[NUM_EXT-1:0];
        REG_EN_INT:  rdata[NUM_INT-1:0] <= enables[NUM_SRC-1:NUM_EXT];
        REG_FLG_EXT: rdata[NUM_EXT-1:0] <= flags[NUM_EXT-1:0];
        REG_FLG_INT: rdata[NUM_INT-1:0] <= flags[NUM_SRC-1:NUM_EXT];
        REG_MASK:    rdata[0]           <= mask;
        default:     rdata              <= '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_ctrl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pending,
  output logic               req_q,
  output logic [VEC_W-1:0]   vec_q
);
  logic [VEC_W-1:0] best;
  logic             found;

  always_comb begin
    best  = '1;
    found = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pending[i] && src_vector(i) < best) begin
        best  = src_vector(i);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      vec_q <= '0;
    end else begin
      req_q <= found;
      vec_q <= found ? best : '0;
    end
  end
endmodule

// File: rtl/irq_edge_ctrl.sv
module irq_edge_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_PIN-1:0] ext_pin,
  input  logic               aux_pin,
  input  logic [NUM_PIN-1:0] pin_sel,
  input  logic [NUM_INT-1:0] int_req,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               irq_ack,
  output logic               irq_req,
  output logic [VEC_W-1:0]   irq_vec
);
  logic [NUM_EXT-1:0] rise_w, fall_w;
  logic [NUM_PIN-1:0] edge_rise_w;
  logic [1:0]         aux_sel_w;
  logic [NUM_SRC-1:0] set_w, flags_w, en_w, pend_w;
  logic               mask_w;

  irq_sync_edge #(.STAGES(SYNC_STAGES), .WIDTH(NUM_EXT)) u_sync (
    .clk(clk), .rst(rst), .pin_in({aux_pin, ext_pin}),
    .rise(rise_w), .fall(fall_w)
  );

  for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
    assign set_w[p] = pin_sel[p] & (edge_rise_w[p] ? rise_w[p] : fall_w[p]);
  end

  always_comb begin
    case (aux_edge_e'(aux_sel_w))
      AUX_FALL: set_w[NUM_PIN] = fall_w[NUM_PIN];
      AUX_RISE: set_w[NUM_PIN] = rise_w[NUM_PIN];
      default:  set_w[NUM_PIN] = rise_w[NUM_PIN] | fall_w[NUM_PIN];
    endcase
  end

  assign set_w[NUM_SRC-1:NUM_EXT] = int_req;

  irq_flag_regs u_regs (
    .clk(clk), .rst(rst), .set_evt(set_w),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .irq_ack(irq_ack), .edge_rise(edge_rise_w), .aux_sel(aux_sel_w),
    .flags(flags_w), .enables(en_w), .mask(mask_w), .rdata(reg_rdata)
  );

  assign pend_w = flags_w & en_w & {NUM_SRC{~mask_w}};

  irq_prio_enc u_prio (
    .clk(clk), .rst(rst), .pending(pend_w),
    .req_q(irq_req), .vec_q(irq_vec)
  );
endmodule

// File: rtl/irq_edge_ctrl_chk.sv
module irq_edge_ctrl_chk
  import irq_ctrl_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               irq_ack,
  input logic [NUM_INT-1:0] int_req,
  input logic [NUM_SRC-1:0] flags,
  input logic               mask,
  input logic               irq_req,
  input logic [VEC_W-1:0]   irq_vec
);
  assert_ack_sets_mask_R9: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> mask);

  assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    mask |=> !irq_req);

  assert_vec_legal_R10: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec inside {5'd4, 5'd5, 5'd6, 5'd11, 5'd12, 5'd14,
                                 5'd15, 5'd18, 5'd19, 5'd20}));

  assert_idle_vec_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> irq_vec == '0);

  for (genvar k = 0; k < NUM_INT; k++) begin : g_strobe
    // R4 and R6: a strobe sets its flag even against a clearing write
    assert_strobe_sets_R4: assert property (@(posedge clk) disable iff (rst)
      int_req[k] |=> flags[NUM_EXT+k]);
  end
endmodule

bind irq_edge_ctrl irq_edge_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .irq_ack(irq_ack), .int_req(int_req),
  .flags(flags_w), .mask(mask_w), .irq_req(irq_req), .irq_vec(irq_vec)
);

// File: tb/test_irq_edge_ctrl.sv
module test_irq_edge_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ext_pin = '0;
  logic       aux_pin = 1'b0;
  logic [1:0] pin_sel = '0;
  logic [6:0] int_req = '0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_ack = 1'b0;
  logic       irq_req;
  logic [4:0] irq_vec;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  irq_edge_ctrl i_irq_edge_ctrl (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .aux_pin(aux_pin),
    .pin_sel(pin_sel), .int_req(int_req), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  function automatic int tb_vec(input int i);
    int t[10] = '{4, 5, 6, 20, 19, 18, 15, 14, 12, 11};
    return t[i];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = int'(reg_rdata);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    int v;
    int exp_v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 irq_req after reset", int'(irq_req), 0);
    chk("R10 idle vector after reset", int'(irq_vec), 0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R11 register reset value", v, 0);
    end

    // R11 configuration readback
    wr(3'd0, 8'h0E); rd(3'd0, v); chk("R11 edge cfg readback", v, 8'h0E);
    wr(3'd2, 8'h5A); rd(3'd2, v); chk("R11 int enable readback", v, 8'h5A);
    wr(3'd2, 8'h00);

    // R1 main pin edge polarity
    pin_sel = 2'b11;
    for (int pol = 0; pol < 2; pol++) begin
      for (int p = 0; p < 2; p++) begin
        wr(3'd0, pol ? 8'h03 : 8'h00);
        wr(3'd3, 8'h00);
        @(negedge clk); ext_pin[p] = 1'b1;
        settle(); rd(3'd3, v);
        chk("R1 flag after rising edge", v, pol ? (1 << p) : 0);
        wr(3'd3, 8'h00);
        @(negedge clk); ext_pin[p] = 1'b0;
        settle(); rd(3'd3, v);
        chk("R1 flag after falling edge", v, pol ? 0 : (1 << p));
        wr(3'd3, 8'h00);
      end
    end

    // R2 auxiliary edge selector
    for (int s = 0; s < 4; s++) begin
      wr(3'd0, 8'(s << 2));
      wr(3'd3, 8'h00);
      @(negedge clk); aux_pin = 1'b1;
      settle(); rd(3'd3, v);
      chk("R2 aux flag on rising edge", v, (s != 0) ? 4 : 0);
      wr(3'd3, 8'h00);
      @(negedge clk); aux_pin = 1'b0;
      settle(); rd(3'd3, v);
      chk("R2 aux flag on falling edge", v, (s != 1) ? 4 : 0);
      wr(3'd3, 8'h00);
    end

    // R3 pin not selected for interrupts
    wr(3'd0, 8'h00);
    pin_sel = 2'b00;
    for (int e = 0; e < 2; e++) begin
      @(negedge clk); ext_pin = e ? 2'b00 : 2'b11;
      settle(); rd(3'd3, v);
      chk("R3 deselected pins leave flags clear", v, 0);
    end
    pin_sel = 2'b11;

    // R4 internal strobes
    for (int k = 0; k < 7; k++) begin
      @(negedge clk); int_req = 7'(1 << k);
      @(negedge clk); int_req = '0;
      rd(3'd4, v);
      chk("R4 internal strobe sets flag", v, 1 << k);
      wr(3'd4, 8'h00);
    end

    // R5 write-zero clears, write-one keeps
    @(negedge clk); int_req = 7'h7F;
    @(negedge clk); int_req = '0;
    wr(3'd4, 8'h55);
    repeat (10) @(negedge clk);
    rd(3'd4, v);
    chk("R5 only zero-written flags clear and others persist", v, 8'h55);

    // R6 set beats clear in same cycle
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 8'h00; int_req = 7'h01;
    @(negedge clk);
    reg_wr = 1'b0; int_req = '0;
    rd(3'd4, v);
    chk("R6 new strobe wins over clearing write", v, 8'h01);
    wr(3'd4, 8'h00);

    // set every flag for the arbitration sweep
    wr(3'd0, 8'h07);
    @(negedge clk); ext_pin = 2'b11; aux_pin = 1'b1; int_req = 7'h7F;
    @(negedge clk); int_req = '0;
    settle();
    rd(3'd3, v); chk("R1 R2 all external flags set", v, 7);

    // R7 R10 exhaustive enable sweep
    for (int e = 0; e < 1024; e++) begin
      int best;
      best = 0;
      for (int i = 9; i >= 0; i--)
        if (e[i] && (best == 0 || tb_vec(i) < best)) best = tb_vec(i);
      wr(3'd1, 8'(e & 7));
      wr(3'd2, 8'(e >> 3));
      repeat (2) @(negedge clk);
      chk("R7 R10 request valid for enable pattern", int'(irq_req), (best != 0) ? 1 : 0);
      chk("R7 R10 vector for enable pattern", int'(irq_vec), best);
    end
    rd(3'd4, v); chk("R7 disabling leaves flags intact", v, 8'h7F);

    // R8 mask blocks everything
    wr(3'd1, 8'h07); wr(3'd2, 8'h7F);
    wr(3'd5, 8'h01);
    repeat (2) @(negedge clk);
    chk("R8 masked request", int'(irq_req), 0);
    chk("R8 masked vector", int'(irq_vec), 0);
    wr(3'd5, 8'h00);
    repeat (2) @(negedge clk);
    chk("R10 unmasked winner", int'(irq_vec), 4);

    // R9 acknowledge sets mask
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    @(negedge clk);
    chk("R9 request drops after acknowledge", int'(irq_req), 0);
    rd(3'd5, v); chk("R9 mask set by acknowledge", v, 1);
    wr(3'd5, 8'h00);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 8'h00; irq_ack = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; irq_ack = 1'b0;
    rd(3'd5, v); chk("R9 acknowledge wins over mask write", v, 1);

    // R10 lowest vector among internal only
    wr(3'd3, 8'h00); wr(3'd5, 8'h00);
    exp_v = 11;
    repeat (2) @(negedge clk);
    chk("R10 internal winner", int'(irq_vec), exp_v);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule